// File: doc/BRIEF.md
# Self-Stalling Execution Unit Pipeline

This block models the timing of one execution unit as a fixed-depth pipeline. An instruction pushed in at the front moves one stage per advance cycle and arrives at the pop end after a configured number of stages. The pipeline never lets an entry fall off its end. When the final stage holds an entry that the consumer has not taken, the whole pipeline freezes and reports that it is stalled. It moves again only once that entry is consumed. A separate issue-gap counter sets the minimum number of cycles between two accepted pushes, independently of the latency. A flush input empties every stage at once.

Empty stages carry a bubble: the valid bit is clear and the data is zero, so stale data never shows. A busy output tells the surrounding logic whether any instruction is still in flight and the unit needs clocking in the next cycle. The arithmetic of the unit and the choice of which unit receives an instruction are handled elsewhere.

Top module: `fu_hold_pipe`

## Requirements
- R1: After reset every stage is empty. pop_valid=0, pop_data=0, stalled=0, busy=0 and push_ready=1.
- R2: Hold advance high and let the final stage be empty or consumed. An accepted push then shows at the pop end exactly LATENCY cycles after the cycle in which it was accepted, and entries keep their push order.
- R3: While advance is low and there is no push, pop or flush, no entry moves and pop_data is unchanged.
- R4: When the final stage is valid and pop_done is low, stalled=1 and nothing moves, even with advance high. The held entry stays at the pop end.
- R5: pop_done with pop_valid high removes the final entry on that edge. If advance is also high in that cycle, the entry behind it moves into the final stage on the same edge.
- R6: push_ready is low when the first stage is occupied and the pipeline will not move in that cycle. A refused push leaves the contents unchanged.
- R7: After an accepted push, push_ready stays low for ISSUE_GAP-1 cycles. With ISSUE_GAP=1, pushes may be back to back.
- R8: Whenever pop_valid is low, pop_data is zero (bubble value).
- R9: busy is high exactly when at least one stage holds an entry.
- R10: flush empties all stages on the next edge and clears the issue gap. push_ready is low while flush is high.
- R11: pop_done while pop_valid is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Empty all stages |
| advance | input | 1 | Per-cycle permission to shift |
| push_valid | input | 1 | An instruction is offered |
| push_data | input | DATA_W | Instruction tag offered |
| push_ready | output | 1 | Offered instruction is accepted this cycle |
| pop_valid | output | 1 | Final stage holds an entry |
| pop_data | output | DATA_W | Tag in the final stage, zero when empty |
| pop_done | input | 1 | Consumer takes the final entry |
| stalled | output | 1 | Final entry is held and blocks shifting |
| busy | output | 1 | Some stage is occupied |

## Verification
The hardest situation to reach is a push offered in the same cycle that the tail is consumed while the pipeline is full behind it. Acceptance then depends on the pop, the advance and the issue gap together. The stimulus table drives the tail into a hold with a second entry parked in stage 0. It then offers a push during the hold, which must be refused. Next it releases the tail with pop_done and re-offers the same push in that cycle. A one-stage instance repeats this with the tail and the first stage being the same register.

// File: rtl/fu_hold_pipe.sv
module fu_hold_pipe #(
  parameter int LATENCY   = 3,
  parameter int ISSUE_GAP = 2,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              advance,
  input  logic              push_valid,
  input  logic [DATA_W-1:0] push_data,
  output logic              push_ready,
  output logic              pop_valid,
  output logic [DATA_W-1:0] pop_data,
  input  logic              pop_done,
  output logic              stalled,
  output logic              busy
);
  localparam int LAST = LATENCY - 1;
  localparam int GW   = (ISSUE_GAP > 1) ? $clog2(ISSUE_GAP) : 1;

  logic [LATENCY-1:0] vld;
  logic [DATA_W-1:0]  dat [LATENCY];
  logic [GW-1:0]      gap_q;
  logic               move, take, pop_fire;

  initial assert (LATENCY >= 1 && LATENCY <= 8 && ISSUE_GAP >= 1);

  assign pop_fire   = pop_done && vld[LAST];
  assign stalled    = vld[LAST] && !pop_done;
  assign move       = advance && !stalled;
  assign push_ready = !flush && (gap_q == '0) && (move || !vld[0]);
  assign take       = push_valid && push_ready;
  assign pop_valid  = vld[LAST];
  assign pop_data   = dat[LAST];
  assign busy       = |vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < LATENCY; i++) dat[i] <= '0;
    end else if (flush) begin
      vld <= '0;
      for (int i = 0; i < LATENCY; i++) dat[i] <= '0;
    end else if (move) begin
      for (int i = LAST; i > 0; i--) begin
        vld[i] <= vld[i-1];
        dat[i] <= dat[i-1];
      end
      vld[0] <= take;
      dat[0] <= take ? push_data : '0;
    end else begin
      if (pop_fire) begin
        vld[LAST] <= 1'b0;
        dat[LAST] <= '0;
      end
      if (take) begin
        vld[0] <= 1'b1;
        dat[0] <= push_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     gap_q <= '0;
    else if (flush)                 gap_q <= '0;
    else if (take)                  gap_q <= GW'(ISSUE_GAP - 1);
    else if (gap_q != '0)           gap_q <= gap_q - 1'b1;
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_valid && !pop_done && !flush) |=> (pop_valid && $stable(pop_data)));

  p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_valid |-> (pop_data == '0));

  p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);

  p_freeze_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !flush && !pop_done && !take) |=> ($stable(vld) && $stable(pop_data)));

  p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_done && !pop_valid && !advance && !flush && !take) |=> $stable(vld));

  p_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[0] && !move) |-> !push_ready);

  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !take) |=> !busy);

  generate
    if (ISSUE_GAP > 1) begin : g_gap
      p_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !push_ready);
    end
    if (LATENCY > 1) begin : g_multi
      p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (move && !flush && vld[0]) |=> vld[1]);
      p_consume_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_fire && !advance && !flush) |=> !pop_valid);
    end
  endgenerate
endmodule

// File: tb/tb_fu_hold_pipe.sv
module tb_fu_hold_pipe;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       flush = 0, advance = 0, push_valid = 0, pop_done = 0;
  logic [7:0] push_data = '0;
  logic       push_ready, pop_valid, stalled, busy;
  logic [7:0] pop_data;

  logic       b_adv = 0, b_pv = 0, b_pop = 0;
  logic [7:0] b_pd = '0;
  logic       b_ready, b_popv, b_stall, b_busy;
  logic [7:0] b_popd;

  fu_hold_pipe #(.LATENCY(3), .ISSUE_GAP(2), .DATA_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .advance(advance),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop_valid(pop_valid), .pop_data(pop_data), .pop_done(pop_done),
    .stalled(stalled), .busy(busy));

  fu_hold_pipe #(.LATENCY(1), .ISSUE_GAP(1), .DATA_W(8)) dut1 (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .advance(b_adv),
    .push_valid(b_pv), .push_data(b_pd), .push_ready(b_ready),
    .pop_valid(b_popv), .pop_data(b_popd), .pop_done(b_pop),
    .stalled(b_stall), .busy(b_busy));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // row: adv, pv, pd[8], pop | e_ready, e_popv, e_popd[8], e_stall, e_busy
  localparam int NV = 13;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,1'b1,8'h11,1'b0, 1'b1,1'b0,8'h00,1'b0,1'b0}, // push A
    {1'b1,1'b1,8'h22,1'b0, 1'b0,1'b0,8'h00,1'b0,1'b1}, // gap refuses B
    {1'b1,1'b1,8'h22,1'b0, 1'b1,1'b0,8'h00,1'b0,1'b1}, // B accepted
    {1'b1,1'b0,8'h00,1'b0, 1'b0,1'b1,8'h11,1'b1,1'b1}, // A held, R4
    {1'b1,1'b1,8'h33,1'b0, 1'b0,1'b1,8'h11,1'b1,1'b1}, // stage0 full, R6
    {1'b1,1'b1,8'h33,1'b1, 1'b1,1'b1,8'h11,1'b0,1'b1}, // pop+push, R5
    {1'b1,1'b0,8'h00,1'b0, 1'b0,1'b0,8'h00,1'b0,1'b1},
    {1'b0,1'b0,8'h00,1'b0, 1'b1,1'b1,8'h22,1'b1,1'b1}, // hold, R3
    {1'b0,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h22,1'b0,1'b1}, // pop w/o advance
    {1'b1,1'b0,8'h00,1'b0, 1'b1,1'b0,8'h00,1'b0,1'b1},
    {1'b1,1'b0,8'h00,1'b0, 1'b1,1'b1,8'h33,1'b1,1'b1},
    {1'b1,1'b0,8'h00,1'b1, 1'b1,1'b1,8'h33,1'b0,1'b1},
    {1'b1,1'b0,8'h00,1'b0, 1'b1,1'b0,8'h00,1'b0,1'b0}  // empty again
  };

  task automatic drive(logic a, logic pv, logic [7:0] pd, logic pp, logic fl);
    @(negedge clk);
    advance = a; push_valid = pv; push_data = pd; pop_done = pp; flush = fl;
    #1;
  endtask

  task automatic drive1(logic a, logic pv, logic [7:0] pd, logic pp);
    @(negedge clk);
    b_adv = a; b_pv = pv; b_pd = pd; b_pop = pp;
    #1;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1", "pop_valid", pop_valid, 0);
    chk("R1", "pop_data", pop_data, 0);
    chk("R1", "stalled", stalled, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "push_ready", push_ready, 1);
    @(negedge clk); rst_n = 1'b1;

    // table: R2 latency 3 (A pushed row 0, visible row 3), R3 R4 R5 R6 R7 R8 R9
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][22], VEC[k][21], VEC[k][20:13], VEC[k][12], 1'b0);
      chk("R7", $sformatf("row%0d push_ready", k), push_ready, VEC[k][11]);
      chk("R2", $sformatf("row%0d pop_valid", k), pop_valid, VEC[k][10]);
      chk("R8", $sformatf("row%0d pop_data", k), pop_data, VEC[k][9:2]);
      chk("R4", $sformatf("row%0d stalled", k), stalled, VEC[k][1]);
      chk("R9", $sformatf("row%0d busy", k), busy, VEC[k][0]);
    end

    // R10 flush
    drive(1, 1, 8'h44, 0, 0);
    chk("R10", "push before flush", push_ready, 1);
    drive(1, 1, 8'h55, 0, 1);
    chk("R10", "push_ready during flush", push_ready, 0);
    drive(1, 0, 8'h00, 0, 0);
    chk("R10", "busy after flush", busy, 0);
    chk("R10", "push_ready after flush", push_ready, 1);
    for (int k = 0; k < 4; k++) begin
      drive(1, 0, 8'h00, 0, 0);
      chk("R10", "nothing emerges", pop_valid, 0);
    end

    // R11 pop_done on empty tail ignored
    drive(1, 1, 8'h66, 0, 0);
    drive(0, 0, 8'h00, 1, 0);
    chk("R11", "busy kept", busy, 1);
    drive(1, 0, 8'h00, 0, 0);
    drive(1, 0, 8'h00, 0, 0);
    drive(1, 0, 8'h00, 0, 0);
    chk("R11", "entry survives valid", pop_valid, 1);
    chk("R11", "entry survives data", pop_data, 8'h66);
    drive(1, 0, 8'h00, 1, 0);
    drive(1, 0, 8'h00, 0, 0);
    chk("R5", "consumed", pop_valid, 0);

    // one-stage instance: R5 R6 R7 with tail == first stage
    drive1(1, 1, 8'h77, 0);
    chk("R7", "L1 back-to-back ready", b_ready, 1);
    drive1(1, 1, 8'h88, 0);
    chk("R4", "L1 stalled", b_stall, 1);
    chk("R6", "L1 refuse while held", b_ready, 0);
    chk("R2", "L1 data", b_popd, 8'h77);
    drive1(1, 1, 8'h88, 1);
    chk("R5", "L1 pop+push ready", b_ready, 1);
    drive1(1, 0, 8'h00, 1);
    chk("R5", "L1 next data", b_popd, 8'h88);
    drive1(1, 0, 8'h00, 0);
    chk("R9", "L1 idle", b_busy, 0);
    chk("R8", "L1 bubble", b_popd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule